// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns a parallel pixel stream into four serial lanes for a low-voltage differential display link. Each pixel clock it takes one pixel: 18 bits of colour (six each of red, green and blue) plus horizontal sync, vertical sync and data-enable. It packs those 21 bits with a fixed 7-bit clock-lane pattern into a 28-bit word. Each of the four lanes then sends 7 bits of that word during the next pixel period, so the bits go out at seven times the pixel rate. Three lanes carry pixel data. The fourth carries a clock pattern whose edges mark the pixel boundaries for the receiver.

Pixel capture runs on the rising edge of the pixel clock only. The serial side runs on a bit clock that is synchronous to the pixel clock at seven times its frequency, with a rising edge on every pixel clock rising edge. A divide-by-seven phase counter in the bit-clock domain finds the pixel boundary once after reset. It then reloads the lane shift registers every seventh bit clock. The parameter `ORDER` selects the bit order within a lane. By default slot 0 of each lane field is sent first and slot 6 last.

Top module: `pixlink_ser7`

## Requirements
- R1: While `rst_n` is low all four lanes drive 0, and after release they stay 0 until the first captured pixel is loaded.
- R2: A pixel present at a rising `pclk` edge is captured there. Slot 0 of every lane (default order) is driven from the first `bclk` rising edge after that edge and held for one bit period.
- R3: Lane 0 (`ser_lane[0]`) carries red bits 0..5 in slots 0..5 and green bit 0 in slot 6.
- R4: Lane 1 (`ser_lane[1]`) carries green bits 1..5 in slots 0..4 and blue bits 0..1 in slots 5..6.
- R5: Lane 2 (`ser_lane[2]`) carries blue bits 2..5 in slots 0..3, HS in slot 4, VS in slot 5 and DE in slot 6.
- R6: Lane 3 (`ser_lane[3]`) carries the pattern 1,1,0,0,0,1,1 in time order in every pixel period, starting with the first pixel after reset.
- R7: With the default order, slot i of each lane leaves in bit period i after the load (slot 0 first, slot 6 last). The other order sends slot 6 first.
- R8: Back-to-back pixels give a continuous stream of exactly seven bits per lane per pixel, with no bit dropped or repeated. The load happens every seventh bit clock.
- R9: Pixel inputs that change between rising `pclk` edges have no effect. Only the value present at the rising edge is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock, rising edge used |
| bclk | input | 1 | Bit clock, 7x `pclk`, edge-aligned with it |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pix_r | input | COLOR_W | Red component |
| pix_g | input | COLOR_W | Green component |
| pix_b | input | COLOR_W | Blue component |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| ser_lane | output | NUM_LANES | Serial lanes; the top index is the clock lane |

## Verification
A pixel captured at a `pclk` rising edge at time T shows slot 0 on the lanes from the `bclk` edge at T+1 bit period, and slot i from T+1+i. The last slot is still held at the next pixel edge. The bench samples every lane on `bclk` falling edges, skipping the first falling edge after the first capture edge (where the lanes must still be quiet). From then on it takes exactly seven consecutive samples per pixel, so a shifted, dropped or repeated bit shows up as a mismatch on every later pixel. The bound checker ties the clock lane and the load strobe to a bit counter, so both can be checked on every cycle.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

   localparam int DEF_COLOR_W   = 6;
   localparam int DEF_LANE_W    = 7;
   localparam int DEF_NUM_LANES = 4;
   localparam logic [DEF_LANE_W-1:0] DEF_CLK_PAT = 7'b1100011;

   // Which slot of a lane field leaves the lane first
   typedef enum logic {
      ORDER_SLOT0_FIRST = 1'b0,
      ORDER_SLOTN_FIRST = 1'b1
   } shift_order_e;

endpackage

// File: rtl/pixlink_packer.sv
// Pixel-clock domain: captures one pixel per rising edge into the lane
// word and flips a marker so the bit domain can find the pixel boundary.
module pixlink_packer #(
   parameter int COLOR_W = pixlink_pkg::DEF_COLOR_W,
   parameter int LANE_W  = pixlink_pkg::DEF_LANE_W,
   parameter int NUM_LANES = pixlink_pkg::DEF_NUM_LANES,
   parameter logic [LANE_W-1:0] CLK_PAT = pixlink_pkg::DEF_CLK_PAT,
   localparam int DATA_W = 3 * COLOR_W + 3,
   localparam int WORD_W = NUM_LANES * LANE_W
) (
   input  logic               pclk,
   input  logic               rst_n,
   input  logic [COLOR_W-1:0] pix_r,
   input  logic [COLOR_W-1:0] pix_g,
   input  logic [COLOR_W-1:0] pix_b,
   input  logic               pix_hs,
   input  logic               pix_vs,
   input  logic               pix_de,
   output logic [WORD_W-1:0]  word_q,
   output logic               mark_q
);

   logic [DATA_W-1:0] data_bits;

   // Concatenated low to high: red, green, blue, HS, VS, DE. Cut into
   // LANE_W-wide fields this gives the documented lane mapping.
   assign data_bits = {pix_de, pix_vs, pix_hs, pix_b, pix_g, pix_r};

   always_ff @(posedge pclk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         mark_q <= 1'b0;
      end else begin
         word_q <= {CLK_PAT, data_bits};
         mark_q <= ~mark_q;
      end
   end

endmodule

// File: rtl/pixlink_phase.sv
// Bit-clock domain divide-by-LANE_W counter: locks to the first pixel
// marker flip and then issues a load strobe every LANE_W bit clocks.
module pixlink_phase #(
   parameter int LANE_W = pixlink_pkg::DEF_LANE_W,
   localparam int PH_W = (LANE_W > 1) ? $clog2(LANE_W) : 1
) (
   input  logic bclk,
   input  logic rst_n,
   input  logic mark,
   output logic load
);

   localparam logic [PH_W-1:0] PH_LAST = PH_W'(LANE_W - 1);

   logic            mark_seen;
   logic            locked;
   logic [PH_W-1:0] phase;
   logic            flip;

   // The marker flips on the pixel edge, which is also a bit edge; the
   // flop below still holds the old value one bit clock later.
   assign flip = mark ^ mark_seen;
   assign load = locked ? (phase == PH_LAST) : flip;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         mark_seen <= 1'b0;
         locked    <= 1'b0;
         phase     <= '0;
      end else begin
         mark_seen <= mark;
         locked    <= locked | flip;
         if (load)
            phase <= '0;
         else if (phase != PH_LAST)
            phase <= phase + 1'b1;
      end
   end

endmodule

// File: rtl/pixlink_lane.sv
// One serial lane: parallel load on the strobe, then one slot per bit clock.
module pixlink_lane
   import pixlink_pkg::*;
#(
   parameter int           LANE_W = DEF_LANE_W,
   parameter shift_order_e ORDER  = ORDER_SLOT0_FIRST
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LANE_W-1:0] par,
   output logic              ser
);

   logic [LANE_W-1:0] sreg;

   generate
      if (ORDER == ORDER_SLOT0_FIRST) begin : g_slot0_first
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n)     sreg <= '0;
            else if (load)  sreg <= par;
            else            sreg <= sreg >> 1;
         end
         assign ser = sreg[0];
      end else begin : g_slotn_first
         always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n)     sreg <= '0;
            else if (load)  sreg <= par;
            else            sreg <= sreg << 1;
         end
         assign ser = sreg[LANE_W-1];
      end
   endgenerate

endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7
   import pixlink_pkg::*;
#(
   parameter int           COLOR_W   = DEF_COLOR_W,
   parameter int           LANE_W    = DEF_LANE_W,
   parameter int           NUM_LANES = DEF_NUM_LANES,
   parameter logic [LANE_W-1:0] CLK_PAT = DEF_CLK_PAT,
   parameter shift_order_e ORDER     = ORDER_SLOT0_FIRST
) (
   input  logic                 pclk,
   input  logic                 bclk,
   input  logic                 rst_n,
   input  logic [COLOR_W-1:0]   pix_r,
   input  logic [COLOR_W-1:0]   pix_g,
   input  logic [COLOR_W-1:0]   pix_b,
   input  logic                 pix_hs,
   input  logic                 pix_vs,
   input  logic                 pix_de,
   output logic [NUM_LANES-1:0] ser_lane
);

   localparam int DATA_W = 3 * COLOR_W + 3;
   localparam int WORD_W = NUM_LANES * LANE_W;

   generate
      if (DATA_W != (NUM_LANES - 1) * LANE_W) begin : g_bad_fit
         $error("pixel bits must fill every data lane exactly");
      end
      if (LANE_W < 2) begin : g_bad_lane
         $error("a lane needs at least two slots");
      end
   endgenerate

   logic [WORD_W-1:0] word_q;
   logic              mark_q;
   logic              ld_bit;

   pixlink_packer #(
      .COLOR_W(COLOR_W), .LANE_W(LANE_W),
      .NUM_LANES(NUM_LANES), .CLK_PAT(CLK_PAT)
   ) u_packer (
      .pclk(pclk), .rst_n(rst_n),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
      .word_q(word_q), .mark_q(mark_q)
   );

   pixlink_phase #(.LANE_W(LANE_W)) u_phase (
      .bclk(bclk), .rst_n(rst_n), .mark(mark_q), .load(ld_bit)
   );

   generate
      for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
         pixlink_lane #(.LANE_W(LANE_W), .ORDER(ORDER)) u_lane (
            .bclk(bclk), .rst_n(rst_n), .load(ld_bit),
            .par(word_q[l*LANE_W +: LANE_W]),
            .ser(ser_lane[l])
         );
      end
   endgenerate

endmodule

// File: rtl/pixlink_ser7_chk.sv
module pixlink_ser7_chk #(
   parameter int LANE_W    = 7,
   parameter int NUM_LANES = 4,
   parameter logic [LANE_W-1:0] CLK_PAT = 7'b1100011,
   parameter logic SLOT0_FIRST = 1'b1
) (
   input logic                 bclk,
   input logic                 rst_n,
   input logic                 load,
   input logic [NUM_LANES-1:0] lanes
);

   localparam int CW = $clog2(LANE_W);
   localparam logic [CW-1:0] C_LAST = CW'(LANE_W - 1);

   logic          seen;
   logic [CW-1:0] cnt;
   logic [CW-1:0] slot;

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         seen <= 1'b0;
         cnt  <= '0;
      end else begin
         if (load) seen <= 1'b1;
         if (load)                cnt <= '0;
         else if (cnt != C_LAST)  cnt <= cnt + 1'b1;
      end
   end

   assign slot = SLOT0_FIRST ? cnt : (C_LAST - cnt);

   always @(posedge bclk) begin
      if (!rst_n) begin
         p_reset_quiet_r1: assert (lanes == '0)
            else $error("lanes active during reset");
      end
   end

   p_quiet_before_load_r1: assert property (@(posedge bclk) disable iff (!rst_n)
      !seen |-> lanes == '0);

   p_clock_lane_r6: assert property (@(posedge bclk) disable iff (!rst_n)
      seen |-> lanes[NUM_LANES-1] == CLK_PAT[slot]);

   p_load_spacing_r8: assert property (@(posedge bclk) disable iff (!rst_n)
      (seen && load) |-> cnt == C_LAST);

   p_load_due_r8: assert property (@(posedge bclk) disable iff (!rst_n)
      (seen && cnt == C_LAST) |-> load);

endmodule

bind pixlink_ser7 pixlink_ser7_chk #(
   .LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .CLK_PAT(CLK_PAT),
   .SLOT0_FIRST(ORDER == pixlink_pkg::ORDER_SLOT0_FIRST)
) u_chk (
   .bclk(bclk), .rst_n(rst_n), .load(ld_bit), .lanes(ser_lane)
);

// File: tb/pixlink_ser7_tb_top.sv
module pixlink_ser7_tb_top;

   localparam int NPIX = 200;

   logic       pclk = 1'b0;
   logic       bclk = 1'b0;
   logic       rst_n;
   logic [5:0] pix_r, pix_g, pix_b;
   logic       pix_hs, pix_vs, pix_de;
   logic [3:0] ser_lane;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit summary_done = 1'b0;

   logic [5:0] m_r [NPIX];
   logic [5:0] m_g [NPIX];
   logic [5:0] m_b [NPIX];
   logic       m_hs[NPIX];
   logic       m_vs[NPIX];
   logic       m_de[NPIX];
   bit         m_gl[NPIX];

   pixlink_ser7 dut_i (
      .pclk(pclk), .bclk(bclk), .rst_n(rst_n),
      .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
      .ser_lane(ser_lane)
   );

   // 250 MHz bit clock; pixel clock at one seventh, rising with it
   always #2 bclk = ~bclk;
   initial begin
      #2;
      forever begin
         pclk = 1'b1; #14;
         pclk = 1'b0; #14;
      end
   end

   // Expected lane field, slot 6 at the left
   function automatic logic [6:0] exp_lane(input int k, input int lane);
      case (lane)
         0:       return {m_g[k][0], m_r[k]};
         1:       return {m_b[k][1:0], m_g[k][5:1]};
         2:       return {m_de[k], m_vs[k], m_hs[k], m_b[k][5:2]};
         default: return 7'b1100011;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input int k);
      if (k < NPIX) begin
         pix_r = m_r[k]; pix_g = m_g[k]; pix_b = m_b[k];
         pix_hs = m_hs[k]; pix_vs = m_vs[k]; pix_de = m_de[k];
      end else begin
         pix_r = '0; pix_g = '0; pix_b = '0;
         pix_hs = 1'b0; pix_vs = 1'b0; pix_de = 1'b0;
      end
   endtask

   task automatic summary();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Pixel table: directed corners first, then seeded random
   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < NPIX; k++) begin
         m_r[k] = 6'($urandom); m_g[k] = 6'($urandom); m_b[k] = 6'($urandom);
         m_hs[k] = 1'($urandom); m_vs[k] = 1'($urandom); m_de[k] = 1'($urandom);
         m_gl[k] = (k % 5 == 3);
      end
      m_r[0] = '0; m_g[0] = '0; m_b[0] = '0; m_hs[0] = 0; m_vs[0] = 0; m_de[0] = 0;
      m_r[1] = '1; m_g[1] = '1; m_b[1] = '1; m_hs[1] = 1; m_vs[1] = 1; m_de[1] = 1;
      m_r[2] = '0; m_g[2] = '0; m_b[2] = '0; m_hs[2] = 1; m_vs[2] = 0; m_de[2] = 0;
      m_r[3] = '0; m_g[3] = '0; m_b[3] = '0; m_hs[3] = 0; m_vs[3] = 1; m_de[3] = 0;
      m_r[4] = '0; m_g[4] = '0; m_b[4] = '0; m_hs[4] = 0; m_vs[4] = 0; m_de[4] = 1;
      m_r[5] = 6'h01; m_g[5] = 6'h21; m_b[5] = 6'h03; m_hs[5] = 0; m_vs[5] = 0; m_de[5] = 0;
      m_r[6] = 6'h2a; m_g[6] = 6'h15; m_b[6] = 6'h2a; m_hs[6] = 1; m_vs[6] = 0; m_de[6] = 1;
   end

   // Stimulus
   initial begin
      rst_n = 1'b1;
      drive(NPIX);
      #1 rst_n = 1'b0;
      // R1: quiet during reset
      for (int i = 0; i < 6; i++) begin
         @(negedge bclk);
         chk(ser_lane == 4'b0, "R1", "lanes in reset", 32'(ser_lane), 0);
      end
      @(negedge pclk);
      rst_n = 1'b1;
      drive(0);
      for (int k = 0; k < NPIX + 3; k++) begin
         if (k > 0) begin
            @(negedge pclk);
            drive(k);
         end
         if (k < NPIX && m_gl[k]) begin
            // R9: garbage between rising edges must not reach the lanes
            @(posedge pclk);
            #6;
            pix_r = 6'($urandom) ^ 6'h3f; pix_g = ~m_g[k]; pix_b = ~m_b[k];
            pix_hs = ~m_hs[k]; pix_vs = ~m_vs[k]; pix_de = ~m_de[k];
         end
      end
   end

   // Deserializer: seven consecutive bclk falling-edge samples per pixel
   initial begin
      logic [6:0] got [4];
      int good;
      good = 0;
      @(posedge rst_n);
      @(posedge pclk);
      @(negedge bclk);
      // R1/R2: still quiet one half bit after the first capture edge
      chk(ser_lane == 4'b0, "R1", "lanes before first load", 32'(ser_lane), 0);
      for (int k = 0; k < NPIX; k++) begin
         for (int i = 0; i < 7; i++) begin
            @(negedge bclk);
            // R7: the i-th bit in time fills slot i
            for (int l = 0; l < 4; l++) got[l][i] = ser_lane[l];
            if (k == 0 && i == 0)
               chk(ser_lane[3] == 1'b1, "R2", "clock lane slot0 one bit after capture",
                   32'(ser_lane[3]), 1);
         end
         chk(got[0] == exp_lane(k, 0), "R3", $sformatf("lane0 pixel %0d", k),
             32'(got[0]), 32'(exp_lane(k, 0)));
         chk(got[1] == exp_lane(k, 1), "R4", $sformatf("lane1 pixel %0d", k),
             32'(got[1]), 32'(exp_lane(k, 1)));
         chk(got[2] == exp_lane(k, 2), "R5", $sformatf("lane2 pixel %0d", k),
             32'(got[2]), 32'(exp_lane(k, 2)));
         chk(got[3] == 7'b1100011, "R6", $sformatf("clock lane pixel %0d", k),
             32'(got[3]), 32'h63);
         chk(got[2][0] == m_b[k][2], "R7", $sformatf("first bit lane2 pixel %0d", k),
             32'(got[2][0]), 32'(m_b[k][2]));
         if (m_gl[k])
            chk({got[2], got[1], got[0]} == {exp_lane(k, 2), exp_lane(k, 1), exp_lane(k, 0)},
                "R9", $sformatf("glitched pixel %0d", k),
                32'({got[2], got[1], got[0]}),
                32'({exp_lane(k, 2), exp_lane(k, 1), exp_lane(k, 0)}));
         if (got[0] == exp_lane(k, 0) && got[1] == exp_lane(k, 1) &&
             got[2] == exp_lane(k, 2) && got[3] == 7'b1100011)
            good++;
      end
      // R8: continuous stream, every pixel recovered in place
      chk(good == NPIX, "R8", "pixels recovered in sequence", 32'(good), 32'(NPIX));
      done = 1'b1;
      summary();
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge bclk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      summary();
   end

endmodule